// File: doc/BRIEF.md
# Modem Status Change Interrupt Controller

This block watches five modem status flags coming from analog detectors: a weak-signal (long loop) flag, call progress tone detect, answer tone detect, carrier detect and unscrambled mark detect. It passes all five through a two-stage synchroniser and shows them in a status byte. When any of the four detect flags changes level, it latches a pending interrupt. The pending interrupt drives an active-low interrupt pin.

Each change source can be masked by the current transmit mode. While the transmitter is enabled, changes in the two tone detectors are ignored. While DTMF digits are being sent, changes in carrier detect are ignored. Power-down, or a cleared interrupt enable, holds the pin inactive and discards anything pending. A status read clears the pending interrupt at the clock edge that samples the read. A change detected in that same cycle keeps the interrupt set, so no event is lost.

The interrupt logic is a two-state machine. `ST_IDLE` moves to `ST_PEND` on an unmasked change while the interrupt is allowed (allowed means enable high and no power-down). `ST_PEND` returns to `ST_IDLE` on a read with no change in the same cycle. Either state goes to `ST_IDLE` whenever the interrupt is not allowed. Reset enters `ST_IDLE`.

Top module: `mstat_irq`

## Requirements
- R1: `stat_q` bit 0 is long loop, bit 1 call progress, bit 2 answer tone, bit 3 carrier detect and bit 4 unscrambled mark. Bits 7:5 read 0. Each bit follows `stat_in` at the same position and shows a new value after the second rising edge that follows the input change.
- R2: When the interrupt is allowed and no mask applies, a level change on `stat_in` bit 1, 2, 3 or 4 drives `irq_n` low after the third rising edge that follows the input change, and not earlier.
- R3: A change on `stat_in` bit 0 never raises an interrupt.
- R4: While `tx_en` is 1, changes on bits 1 and 2 raise no interrupt.
- R5: While `dtmf_tx` is 1, changes on bit 3 raise no interrupt.
- R6: While `irq_en` is 0, `irq_n` is 1, a pending interrupt is discarded, and changes raise nothing once the enable returns.
- R7: While `pwr_dn` is 1, `irq_n` is 1, a pending interrupt is discarded, and changes raise nothing.
- R8: A pending interrupt holds `irq_n` low until `rd_stb` is sampled high at a rising edge. After that edge `irq_n` is 1.
- R9: A change detected in the same cycle as a clearing read leaves `irq_n` low.
- R10: After reset, `irq_n` is 1 and `stat_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_in | input | 5 | Raw status flags, bit layout as in R1 |
| irq_en | input | 1 | Interrupt enable |
| tx_en | input | 1 | Transmitter enabled; masks the tone detect changes |
| dtmf_tx | input | 1 | DTMF transmission active; masks carrier detect changes |
| pwr_dn | input | 1 | Power-down; disables all interrupts |
| rd_stb | input | 1 | Status read strobe; clears the pending interrupt |
| stat_q | output | 8 | Synchronised status byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: five flags and a two-stage synchroniser. With that small configuration every flag can be toggled in both directions under all four transmit-mask combinations. The expected pin level and the latency are derived arithmetically from the flag index and the masks. Separate passes cover disable, power-down, clearing reads and a read that coincides with a change. Together these reach every state and transition of the interrupt machine.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
    localparam int STAT_W   = 5;
    localparam int BIT_LOOP = 0;
    localparam int BIT_CALL = 1;
    localparam int BIT_ANS  = 2;
    localparam int BIT_CARR = 3;
    localparam int BIT_MARK = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mstat_chg.sv
module mstat_chg
    import mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] cur,
    input  logic              tx_en,
    input  logic              dtmf_tx,
    output logic              chg_any
);
    logic [STAT_W-1:0] prev_q;
    logic [STAT_W-1:0] diff;
    logic [STAT_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    always_comb begin
        mask           = '0;
        mask[BIT_LOOP] = 1'b1;
        mask[BIT_CALL] = tx_en;
        mask[BIT_ANS]  = tx_en;
        mask[BIT_CARR] = dtmf_tx;
        mask[BIT_MARK] = 1'b0;
        diff           = cur ^ prev_q;
        chg_any        = |(diff & ~mask);
    end
endmodule

// File: rtl/mstat_fsm.sv
module mstat_fsm
    import mstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic chg,
    input  logic rd,
    output logic irq_n
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!allow) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (chg)        state_d = ST_PEND;
                ST_PEND: if (rd && !chg) state_d = ST_IDLE;
                default:                 state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = !((state_q == ST_PEND) && allow);
    end
endmodule

// File: rtl/mstat_irq.sv
module mstat_irq
    import mstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              irq_en,
    input  logic              tx_en,
    input  logic              dtmf_tx,
    input  logic              pwr_dn,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] stat_q,
    output logic              irq_n
);
    localparam int PAD_W = BYTE_W - STAT_W;

    logic [STAT_W-1:0] stat_s;
    logic              chg_any;
    logic              allow;

    assign allow = irq_en & ~pwr_dn;

    mstat_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_in),
        .q     (stat_s)
    );

    mstat_chg u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (stat_s),
        .tx_en   (tx_en),
        .dtmf_tx (dtmf_tx),
        .chg_any (chg_any)
    );

    mstat_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .allow (allow),
        .chg   (chg_any),
        .rd    (rd_stb),
        .irq_n (irq_n)
    );

    assign stat_q = {{PAD_W{1'b0}}, stat_s};
endmodule

// File: rtl/mstat_irq_chk.sv
module mstat_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_en,
    input logic       pwr_dn,
    input logic       rd_stb,
    input logic       chg_any,
    input logic       irq_n,
    input logic [7:0] stat_q
);
    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);

    p_pwrdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> irq_n);

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_any && irq_en && !pwr_dn) ##1 (irq_en && !pwr_dn) |-> !irq_n);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !rd_stb) ##1 (irq_en && !pwr_dn) |-> !irq_n);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !chg_any) |=> irq_n);

    p_noloss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && chg_any && irq_en && !pwr_dn) ##1 (irq_en && !pwr_dn) |-> !irq_n);

    p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(chg_any));

    p_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[7:5] == 3'b000);
endmodule

bind mstat_irq mstat_irq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_en  (irq_en),
    .pwr_dn  (pwr_dn),
    .rd_stb  (rd_stb),
    .chg_any (chg_any),
    .irq_n   (irq_n),
    .stat_q  (stat_q)
);

// File: tb/sim_mstat_irq.sv
module sim_mstat_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] stat_in = '0;
    logic       irq_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       dtmf_tx = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] stat_q;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    logic [4:0] model = '0;

    always #5 clk = ~clk;

    mstat_irq u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_in (stat_in),
        .irq_en  (irq_en),
        .tx_en   (tx_en),
        .dtmf_tx (dtmf_tx),
        .pwr_dn  (pwr_dn),
        .rd_stb  (rd_stb),
        .stat_q  (stat_q),
        .irq_n   (irq_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        tick(1);
        rd_stb = 1'b0;
    endtask

    task automatic flip(input int b);
        model[b] = ~model[b];
        stat_in  = model;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tick(3);
        chk(irq_n == 1'b1, "R10 irq_n", irq_n, 1);
        chk(stat_q == 8'h00, "R10 stat_q", stat_q, 0);
        rst_n = 1'b1;
        irq_en = 1'b1;
        tick(3);

        // sweep: every flag, both directions, all mask combinations
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 5; b++) begin
                for (int d = 0; d < 2; d++) begin
                    bit ex;
                    string tag;
                    tx_en   = m[0];
                    dtmf_tx = m[1];
                    tick(1);
                    ex  = (b != 0) && !((b == 1 || b == 2) && m[0]) && !(b == 3 && m[1]);
                    tag = (b == 0) ? "R3" : ((b == 1 || b == 2) && m[0]) ? "R4" :
                          (b == 3 && m[1]) ? "R5" : "R2";
                    flip(b);
                    tick(1);
                    chk(stat_q != {3'b000, model}, "R1 early stat", stat_q, {3'b000, model});
                    tick(1);
                    chk(stat_q == {3'b000, model}, "R1 stat", stat_q, {3'b000, model});
                    chk(irq_n == 1'b1, "R2 not early", irq_n, 1);
                    tick(1);
                    chk(irq_n == !ex, tag, irq_n, !ex);
                    tick(2);
                    chk(irq_n == !ex, "R8 held", irq_n, !ex);
                    do_read();
                    chk(irq_n == 1'b1, "R8 cleared", irq_n, 1);
                end
            end
        end
        tx_en = 1'b0;
        dtmf_tx = 1'b0;
        tick(2);

        // R9: read coincides with detected change
        flip(4);
        tick(3);
        chk(irq_n == 1'b0, "R9 setup", irq_n, 0);
        flip(2);
        tick(2);
        rd_stb = 1'b1;
        tick(1);
        rd_stb = 1'b0;
        chk(irq_n == 1'b0, "R9 kept", irq_n, 0);
        do_read();
        chk(irq_n == 1'b1, "R9 final clear", irq_n, 1);

        // R6: enable low drops pending and blocks changes
        flip(3);
        tick(3);
        chk(irq_n == 1'b0, "R6 setup", irq_n, 0);
        irq_en = 1'b0;
        tick(1);
        chk(irq_n == 1'b1, "R6 gated", irq_n, 1);
        flip(1);
        tick(4);
        chk(irq_n == 1'b1, "R6 change ignored", irq_n, 1);
        irq_en = 1'b1;
        tick(2);
        chk(irq_n == 1'b1, "R6 pending discarded", irq_n, 1);

        // R7: power-down
        flip(2);
        tick(3);
        chk(irq_n == 1'b0, "R7 setup", irq_n, 0);
        pwr_dn = 1'b1;
        tick(1);
        chk(irq_n == 1'b1, "R7 gated", irq_n, 1);
        flip(4);
        tick(4);
        chk(irq_n == 1'b1, "R7 change ignored", irq_n, 1);
        pwr_dn = 1'b0;
        tick(2);
        chk(irq_n == 1'b1, "R7 pending discarded", irq_n, 1);
        chk(stat_q == {3'b000, model}, "R1 final stat", stat_q, {3'b000, model});

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule